// File: doc/BRIEF.md
# Single-Cycle 8-Bit Register Processor Core

This block is a small processor core. Every instruction finishes in one clock. Instructions are 16 bits wide. The datapath, the program counter and the sixteen general registers are all 8 bits wide. Each clock, the core presents its program counter on a fetch port and decodes the word that comes back in the same cycle. It then either updates one register, writes one data byte, or redirects the program counter. All of this is settled by the next rising edge.

Every instruction has one layout. Bits 15 to 12 are the operation, bits 11 to 8 name one register, and bits 7 to 0 are a byte. That byte is an immediate, an absolute data address or a code target. The core has an instruction port and a separate data port. Both memories are outside the core. Reads from them are combinational and writes to the data memory happen on the clock edge.

The instruction set has seven operations: add-immediate, subtract-immediate, load, store, branch-if-register-zero, jump and jump-and-link. Register 0 is hard-wired to zero. Arithmetic wraps modulo 256 and no flags are stored.

Top module: `cpu8_core`

## Requirements
- R1: While `rst_n` is low, the fetch address is 0 and `dmem_we` is low. After reset, every register reads as 0.
- R2: Opcode 0 (add-immediate) writes reg + imm8 modulo 256 into the named register and advances the PC by 2.
- R3: Opcode 1 (subtract-immediate) writes reg - imm8 modulo 256 into the named register and advances the PC by 2.
- R4: Opcode 2 (load) puts bits 7-0 of the instruction on `dmem_addr` and writes `dmem_rdata` into the named register.
- R5: Opcode 3 (store) raises `dmem_we` for that one cycle, with `dmem_addr` equal to bits 7-0 and `dmem_wdata` equal to the named register. `dmem_we` is low for every other opcode. A load from the same address later returns the stored byte.
- R6: Register 0 (bits 11-8 = 0) always reads as 0. Writes to it are discarded.
- R7: Opcode 4 (branch) sets the next PC to PC + 2 + imm8 modulo 256 when the named register is zero, and to PC + 2 otherwise.
- R8: Opcode 5 (jump) sets the next PC to imm8.
- R9: Opcode 6 (jump-and-link) writes PC + 2 into the named register and sets the next PC to imm8, both in the same cycle.
- R10: Opcodes 7 to 15 change no register and no memory. They only advance the PC by 2.
- R11: Opcodes 0 to 3 advance the PC by 2 modulo 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_addr | output | 8 | Fetch address (the program counter) |
| imem_data | input | 16 | Instruction word at `imem_addr` |
| dmem_addr | output | 8 | Data address (instruction bits 7-0) |
| dmem_wdata | output | 8 | Store data |
| dmem_we | output | 1 | Data write enable, sampled on the rising edge |
| dmem_rdata | input | 8 | Data byte at `dmem_addr` |

## Verification
Jump-and-link does two things in the same clock: it writes the link value into the register file and it redirects the program counter. Either one can go wrong without the other. The programs place a jump-and-link and then store its link register at the jump target. The store checks the register write, and the fetch-address trace checks the redirect. A jump-and-link aimed at register 0 confirms that the redirect still happens while the link write is dropped. A branch whose target wraps past 255 exercises the zero test and the branch adder in the same cycle.

// File: rtl/cpu8_pkg.sv
package cpu8_pkg;

  localparam int OPC_W = 4;

  typedef enum logic [OPC_W-1:0] {
    OP_ADDI  = 4'd0,
    OP_SUBI  = 4'd1,
    OP_LOAD  = 4'd2,
    OP_STORE = 4'd3,
    OP_BRZ   = 4'd4,
    OP_JMP   = 4'd5,
    OP_JAL   = 4'd6
  } opcode_e;

  typedef enum logic [2:0] {
    ALU_SUB   = 3'd1,
    ALU_ADD   = 3'd2,
    ALU_PASSX = 3'd3,
    ALU_PASSY = 3'd4
  } alu_op_e;

  typedef enum logic [1:0] {
    WB_ALU  = 2'd0,
    WB_MEM  = 2'd1,
    WB_LINK = 2'd2
  } wb_sel_e;

  typedef enum logic [1:0] {
    PC_SEQ = 2'd0,
    PC_BRZ = 2'd1,
    PC_ABS = 2'd2
  } pc_sel_e;

  typedef struct packed {
    logic    reg_we;
    logic    mem_we;
    alu_op_e alu_op;
    wb_sel_e wb_sel;
    pc_sel_e pc_sel;
  } ctl_t;

  function automatic ctl_t decode_op(logic [OPC_W-1:0] opc);
    ctl_t c;
    c.reg_we = 1'b0;
    c.mem_we = 1'b0;
    c.alu_op = ALU_PASSX;
    c.wb_sel = WB_ALU;
    c.pc_sel = PC_SEQ;
    case (opc)
      OP_ADDI:  begin c.reg_we = 1'b1; c.alu_op = ALU_ADD; end
      OP_SUBI:  begin c.reg_we = 1'b1; c.alu_op = ALU_SUB; end
      OP_LOAD:  begin c.reg_we = 1'b1; c.wb_sel = WB_MEM; c.alu_op = ALU_PASSY; end
      OP_STORE: begin c.mem_we = 1'b1; end
      OP_BRZ:   begin c.pc_sel = PC_BRZ; end
      OP_JMP:   begin c.pc_sel = PC_ABS; c.alu_op = ALU_PASSY; end
      OP_JAL:   begin c.reg_we = 1'b1; c.wb_sel = WB_LINK; c.pc_sel = PC_ABS; end
      default:  ;
    endcase
    return c;
  endfunction

  function automatic logic [7:0] wrap_add8(logic [7:0] a, logic [7:0] b);
    return a + b;
  endfunction

endpackage

// File: rtl/cpu8_decode.sv
module cpu8_decode
  import cpu8_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int RSEL_W = 4,
  localparam int INSN_W = OPC_W + RSEL_W + DATA_W
) (
  input  logic [INSN_W-1:0] insn,
  output logic [OPC_W-1:0]  opc,
  output logic [RSEL_W-1:0] rsel,
  output logic [DATA_W-1:0] imm,
  output ctl_t              ctl
);
  assign opc  = insn[INSN_W-1 -: OPC_W];
  assign rsel = insn[DATA_W +: RSEL_W];
  assign imm  = insn[DATA_W-1:0];
  assign ctl  = decode_op(opc);
endmodule

// File: rtl/cpu8_regfile.sv
module cpu8_regfile #(
  parameter int W = 8,
  parameter int N = 16,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] regs_q [N];

  for (genvar g = 0; g < N; g++) begin : g_reg
    if (g == 0) begin : g_zero
      assign regs_q[g] = '0;
    end else begin : g_store
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          regs_q[g] <= '0;
        else if (we && waddr == AW'(g))
          regs_q[g] <= wdata;
      end
    end
  end

  assign rdata = regs_q[raddr];
endmodule

// File: rtl/cpu8_alu.sv
module cpu8_alu
  import cpu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  alu_op_e      op,
  output logic [W-1:0] res,
  output logic         zero
);
  always_comb begin
    case (op)
      ALU_SUB:   res = x - y;
      ALU_ADD:   res = x + y;
      ALU_PASSX: res = x;
      ALU_PASSY: res = y;
      default:   res = x;
    endcase
  end
  assign zero = (res == '0);
endmodule

// File: rtl/cpu8_pcu.sv
module cpu8_pcu
  import cpu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  pc_sel_e      sel,
  input  logic         reg_zero,
  input  logic [W-1:0] imm,
  output logic [W-1:0] pc,
  output logic [W-1:0] pc_plus2,
  output logic         taken
);
  logic [W-1:0] br_tgt;
  logic [W-1:0] next_pc;

  assign pc_plus2 = pc + W'(2);
  assign br_tgt   = pc_plus2 + imm;
  assign taken    = (sel == PC_BRZ) && reg_zero;

  always_comb begin
    case (sel)
      PC_BRZ:  next_pc = reg_zero ? br_tgt : pc_plus2;
      PC_ABS:  next_pc = imm;
      default: next_pc = pc_plus2;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc <= '0;
    else        pc <= next_pc;
  end
endmodule

// File: rtl/cpu8_core.sv
module cpu8_core
  import cpu8_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int REG_CNT = 16
) (
  input  logic                                       clk,
  input  logic                                       rst_n,
  output logic [DATA_W-1:0]                          imem_addr,
  input  logic [OPC_W+$clog2(REG_CNT)+DATA_W-1:0]    imem_data,
  output logic [DATA_W-1:0]                          dmem_addr,
  output logic [DATA_W-1:0]                          dmem_wdata,
  output logic                                       dmem_we,
  input  logic [DATA_W-1:0]                          dmem_rdata
);
  localparam int RSEL_W = $clog2(REG_CNT);

  logic [OPC_W-1:0]  opc;
  logic [RSEL_W-1:0] rsel;
  logic [DATA_W-1:0] imm;
  ctl_t              ctl;
  logic [DATA_W-1:0] rs_val;
  logic [DATA_W-1:0] alu_res;
  logic              alu_zero;
  logic [DATA_W-1:0] pc;
  logic [DATA_W-1:0] pc_plus2;
  logic              br_taken;
  logic [DATA_W-1:0] wb_data;
  logic              wb_en;

  cpu8_decode #(.DATA_W(DATA_W), .RSEL_W(RSEL_W)) u_dec (
    .insn(imem_data), .opc(opc), .rsel(rsel), .imm(imm), .ctl(ctl)
  );

  cpu8_regfile #(.W(DATA_W), .N(REG_CNT)) u_rf (
    .clk(clk), .rst_n(rst_n), .we(wb_en), .waddr(rsel), .wdata(wb_data),
    .raddr(rsel), .rdata(rs_val)
  );

  cpu8_alu #(.W(DATA_W)) u_alu (
    .x(rs_val), .y(imm), .op(ctl.alu_op), .res(alu_res), .zero(alu_zero)
  );

  cpu8_pcu #(.W(DATA_W)) u_pcu (
    .clk(clk), .rst_n(rst_n), .sel(ctl.pc_sel), .reg_zero(alu_zero),
    .imm(imm), .pc(pc), .pc_plus2(pc_plus2), .taken(br_taken)
  );

  always_comb begin
    case (ctl.wb_sel)
      WB_MEM:  wb_data = dmem_rdata;
      WB_LINK: wb_data = pc_plus2;
      default: wb_data = alu_res;
    endcase
  end

  assign wb_en      = ctl.reg_we;
  assign imem_addr  = pc;
  assign dmem_addr  = imm;
  assign dmem_wdata = alu_res;
  assign dmem_we    = ctl.mem_we & rst_n;
endmodule

// File: rtl/cpu8_core_chk.sv
module cpu8_core_chk #(
  parameter int DATA_W = 8,
  parameter int INSN_W = 16,
  parameter int RSEL_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] imem_addr,
  input logic [INSN_W-1:0] imem_data,
  input logic              dmem_we,
  input logic [DATA_W-1:0] dmem_addr,
  input logic [RSEL_W-1:0] rsel,
  input logic [DATA_W-1:0] rs_val,
  input logic              br_taken
);
  logic [3:0]        op;
  logic [DATA_W-1:0] field;
  assign op    = imem_data[INSN_W-1 -: 4];
  assign field = imem_data[DATA_W-1:0];

  // R1
  reset_pc_chk: assert property (@(posedge clk) !rst_n |-> (imem_addr == '0 && !dmem_we));

  // R5
  store_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_we |-> (op == 4'd3 && dmem_addr == field));

  // R11
  seq_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op <= 4'd3 || op >= 4'd7) |=> imem_addr == $past(imem_addr) + DATA_W'(2));

  // R8
  jmp_tgt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 4'd5) |=> imem_addr == $past(field));

  // R9
  jal_tgt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 4'd6) |=> imem_addr == $past(field));

  // R7
  brz_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 4'd4 && rs_val != '0) |=> imem_addr == $past(imem_addr) + DATA_W'(2));

  // R7
  brz_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    br_taken |=> imem_addr == $past(imem_addr) + DATA_W'(2) + $past(field));

  // R6
  zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsel == '0) |-> rs_val == '0);
endmodule

bind cpu8_core cpu8_core_chk #(
  .DATA_W(DATA_W), .INSN_W(cpu8_pkg::OPC_W + $clog2(REG_CNT) + DATA_W), .RSEL_W($clog2(REG_CNT))
) u_chk (
  .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_data(imem_data),
  .dmem_we(dmem_we), .dmem_addr(dmem_addr), .rsel(rsel), .rs_val(rs_val),
  .br_taken(br_taken)
);

// File: tb/cpu8_core_test.sv
`timescale 1ns/1ps
module cpu8_core_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  imem_addr;
  logic [15:0] imem_data;
  logic [7:0]  dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we;

  logic [15:0] imem [256];
  logic [7:0]  dmem [256];
  string       ptag [256];

  int n_cmp = 0;
  int n_bad = 0;
  logic mon_on = 1'b0;
  logic done = 1'b0;

  logic [7:0] q_pc[$], q_addr[$], q_data[$];
  logic       q_we[$];
  string      q_tag[$];

  always #2 clk = ~clk;

  cpu8_core uut (
    .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_data(imem_data),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
    .dmem_rdata(dmem_rdata)
  );

  assign imem_data  = imem[imem_addr];
  assign dmem_rdata = dmem[dmem_addr];
  always @(posedge clk) if (dmem_we) dmem[dmem_addr] <= dmem_wdata;

  task automatic chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] enc(int op, int r, logic [7:0] v);
    return {op[3:0], r[3:0], v};
  endfunction

  task automatic put(logic [7:0] a, logic [15:0] w, string tag);
    imem[a] = w;
    ptag[a] = tag;
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 256; i++) begin
      imem[i] = 16'h7000;
      ptag[i] = "R11";
      dmem[i] = 8'(i * 3 + 1);
    end
  endtask

  // Driver: independent instruction-level model pushes the expected per-cycle trace.
  task automatic push_expect(int ncyc);
    logic [7:0] r [16];
    logic [7:0] m [256];
    logic [7:0] pc, nxt, rv, v;
    logic [15:0] w;
    int op, rs;
    for (int i = 0; i < 16; i++) r[i] = 8'h00;
    for (int i = 0; i < 256; i++) m[i] = dmem[i];
    pc = 8'h00;
    for (int c = 0; c < ncyc; c++) begin
      w  = imem[pc];
      op = int'(w[15:12]);
      rs = int'(w[11:8]);
      v  = w[7:0];
      rv = (rs == 0) ? 8'h00 : r[rs];
      q_pc.push_back(pc);
      q_we.push_back(op == 3);
      q_addr.push_back(v);
      q_data.push_back(rv);
      q_tag.push_back(ptag[pc]);
      nxt = pc + 8'd2;
      case (op)
        0: if (rs != 0) r[rs] = rv + v;
        1: if (rs != 0) r[rs] = rv - v;
        2: if (rs != 0) r[rs] = m[v];
        3: m[v] = rv;
        4: if (rv == 8'h00) nxt = pc + 8'd2 + v;
        5: nxt = v;
        6: begin if (rs != 0) r[rs] = pc + 8'd2; nxt = v; end
        default: ;
      endcase
      pc = nxt;
    end
  endtask

  // Monitor: pops one expected cycle per falling edge.
  always @(negedge clk) begin
    if (mon_on && q_pc.size() > 0) begin
      logic [7:0] epc, ea, ed;
      logic ewe;
      string t;
      epc = q_pc.pop_front();
      ewe = q_we.pop_front();
      ea  = q_addr.pop_front();
      ed  = q_data.pop_front();
      t   = q_tag.pop_front();
      chk(t, "fetch pc", imem_addr, epc);
      chk(ewe ? "R5" : t, "dmem_we", {7'd0, dmem_we}, {7'd0, ewe});
      if (ewe) begin
        chk(t, "store addr", dmem_addr, ea);
        chk(t, "store data", dmem_wdata, ed);
      end
    end
  end

  task automatic run_prog(int ncyc);
    rst_n = 1'b0;
    push_expect(ncyc);
    repeat (2) @(negedge clk);
    chk("R1", "reset pc", imem_addr, 8'h00);
    chk("R1", "reset we", {7'd0, dmem_we}, 8'h00);
    @(posedge clk);
    #1;
    rst_n  = 1'b1;
    mon_on = 1'b1;
    wait (q_pc.size() == 0);
    @(posedge clk);
    #1;
    mon_on = 1'b0;
  endtask

  initial begin
    // Program 1: arithmetic, wrap, register 0, load/store, no-op opcodes
    clear_prog();
    put(8'h00, enc(0, 1, 8'hF0), "R2");
    put(8'h02, enc(0, 1, 8'h20), "R2");
    put(8'h04, enc(3, 1, 8'h80), "R2");
    put(8'h06, enc(1, 2, 8'h01), "R3");
    put(8'h08, enc(3, 2, 8'h81), "R3");
    put(8'h0A, enc(0, 0, 8'h05), "R6");
    put(8'h0C, enc(3, 0, 8'h82), "R6");
    put(8'h0E, enc(3, 5, 8'h83), "R1");
    put(8'h10, enc(2, 3, 8'h40), "R4");
    put(8'h12, enc(3, 3, 8'h84), "R4");
    put(8'h14, enc(7, 1, 8'h55), "R10");
    put(8'h16, enc(15, 1, 8'hAA), "R10");
    put(8'h18, enc(3, 1, 8'h85), "R10");
    put(8'h1A, enc(3, 2, 8'h40), "R5");
    put(8'h1C, enc(2, 6, 8'h40), "R5");
    put(8'h1E, enc(3, 6, 8'h86), "R5");
    put(8'h20, enc(1, 3, dmem[8'h40]), "R3");
    put(8'h22, enc(1, 3, 8'h5B), "R3");
    put(8'h24, enc(3, 3, 8'h87), "R3");
    put(8'h26, enc(5, 0, 8'h26), "R8");
    run_prog(24);

    // Program 2: branches, jumps, links, wrapped branch target
    clear_prog();
    put(8'h00, enc(4, 0, 8'h04), "R7");
    put(8'h02, enc(3, 0, 8'hA0), "R7");
    put(8'h06, enc(0, 1, 8'h01), "R2");
    put(8'h08, enc(4, 1, 8'h10), "R7");
    put(8'h0A, enc(6, 4, 8'h40), "R9");
    put(8'h40, enc(3, 4, 8'h90), "R9");
    put(8'h42, enc(6, 0, 8'h50), "R9");
    put(8'h50, enc(3, 0, 8'h91), "R6");
    put(8'h52, enc(4, 0, 8'hF0), "R7");
    put(8'h44, enc(3, 1, 8'h92), "R7");
    put(8'h46, enc(6, 7, 8'h60), "R9");
    put(8'h60, enc(3, 7, 8'h93), "R9");
    put(8'h62, enc(1, 7, 8'h48), "R3");
    put(8'h64, enc(4, 7, 8'h06), "R7");
    put(8'h6C, enc(5, 0, 8'h6C), "R8");
    run_prog(18);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog R11 actual=%h expected=%h", 8'h00, 8'h01);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule